// File: doc/BRIEF.md
# Tile Network Port Controller

This block is a memory-mapped slave that sits between a processor tile's 32-bit on-chip bus and one local port of a mesh router. Software loads a data word, then writes a destination column and row. Writing the destination launches the word toward the router on a four-phase request/acknowledge link. While that link is in flight, further transmit writes are refused and flagged.

In the other direction the block takes one word at a time from the router. It keeps the word together with the sender's column and row. Software learns of the arrival by polling a status flag or through a level interrupt, which a control bit gates. The block does not acknowledge a new word until software has read the previous one, so a word that has not been read is never lost. The tile's own column and row are fixed parameters and can be read in the status word.

Top module: `nic_tile_port`

## Requirements
- R1: After reset, tx_req, rx_ack and irq are low. The status word reads only the own-location fields. The receive data and the control word read zero.
- R2: A write to offset 1 (destination: x in bits [COORD_W-1:0], y in bits [2*COORD_W-1:COORD_W]) while idle raises tx_req one cycle later. tx_flit is then {y, x, data}, with the data in bits [31:0], x above it and y on top. The data is the last word written to offset 0. Status bit 0 (busy) is set.
- R3: tx_req stays high until tx_ack is seen high, then falls on the next cycle. Busy clears the cycle after tx_ack is seen low. tx_flit does not change while busy.
- R4: While busy, a write to offset 0 or 1 is ignored, including one in the cycle the handshake retires. The ignored write sets the sticky error bit, status bit 2.
- R5: Writing the status word (offset 3) with bit 2 set clears the error bit. With bit 2 clear, the error bit is kept.
- R6: When rx_req is high and no word is held, the block captures rx_flit (same field layout as tx_flit) and raises rx_ack the next cycle. It sets status bit 1 (rx_valid). rx_ack falls the cycle after rx_req is seen low.
- R7: While rx_valid is set, rx_ack stays low and the held word is not overwritten.
- R8: Reading offset 2 returns the held data and clears rx_valid from the next cycle on. Status bits [16+:COORD_W] and [20+:COORD_W] give the sender's x and y.
- R9: Control bit 0 at offset 4 is the interrupt enable and reads back. irq is high exactly when rx_valid and the enable are both set.
- R10: Status bits [8+:COORD_W] and [12+:COORD_W] always show the parameters MY_X and MY_Y. Software writes cannot change them.
- R11: Offsets 0, 1, 5, 6 and 7 read as zero, and writes to 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, same cycle as the access |
| irq | output | 1 | Level receive interrupt |
| tx_req | output | 1 | Outgoing request |
| tx_ack | input | 1 | Outgoing acknowledge from router |
| tx_flit | output | BUS_W+2*COORD_W | Outgoing word with destination |
| rx_req | input | 1 | Incoming request from router |
| rx_ack | output | 1 | Incoming acknowledge |
| rx_flit | input | BUS_W+2*COORD_W | Incoming word with source |

## Verification
Two cases can land in the same cycle: software reading the receive register, and the router raising a request for the next word. The bench keeps a second word waiting on rx_req while the first is still held. It then issues the read in a cycle where that request is high. The check is that the capture happens exactly one cycle later and that neither word is lost. On the transmit side, a new destination write is issued in the very cycle the acknowledge falls. That write must be refused and flagged. A behavioural model compares every output on every clock.

// File: rtl/nic_pkg.sv
package nic_pkg;
    // word offsets on the bus
    localparam int OFF_TXDATA = 0;
    localparam int OFF_TXDEST = 1;
    localparam int OFF_RXDATA = 2;
    localparam int OFF_STATUS = 3;
    localparam int OFF_CTRL   = 4;

    // status word field positions
    localparam int ST_BUSY = 0;
    localparam int ST_RXV  = 1;
    localparam int ST_ERR  = 2;
    localparam int ST_OWNX = 8;
    localparam int ST_OWNY = 12;
    localparam int ST_SRCX = 16;
    localparam int ST_SRCY = 20;

    typedef enum logic [1:0] {TX_IDLE, TX_REQ_HIGH, TX_REQ_LOW} tx_state_e;
    typedef enum logic {RX_WAIT, RX_ACKING} rx_state_e;
endpackage

// File: rtl/nic_bus_decode.sv
module nic_bus_decode
    import nic_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int BUS_W  = 32
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  status_word,
    input  logic [BUS_W-1:0]  rx_word,
    input  logic [BUS_W-1:0]  ctrl_word,
    output logic              wr_txd,
    output logic              wr_dst,
    output logic              wr_sts,
    output logic              wr_ctl,
    output logic              rd_rx,
    output logic [BUS_W-1:0]  bus_rdata
);
    always_comb begin
        wr_txd    = 1'b0;
        wr_dst    = 1'b0;
        wr_sts    = 1'b0;
        wr_ctl    = 1'b0;
        rd_rx     = 1'b0;
        bus_rdata = '0;
        if (bus_sel && bus_wr) begin
            case (bus_addr)
                ADDR_W'(OFF_TXDATA): wr_txd = 1'b1;
                ADDR_W'(OFF_TXDEST): wr_dst = 1'b1;
                ADDR_W'(OFF_STATUS): wr_sts = 1'b1;
                ADDR_W'(OFF_CTRL):   wr_ctl = 1'b1;
                default: ;
            endcase
        end else if (bus_sel) begin
            case (bus_addr)
                ADDR_W'(OFF_RXDATA): begin
                    bus_rdata = rx_word;
                    rd_rx     = 1'b1;
                end
                ADDR_W'(OFF_STATUS): bus_rdata = status_word;
                ADDR_W'(OFF_CTRL):   bus_rdata = ctrl_word;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/nic_tx_ctrl.sv
module nic_tx_ctrl
    import nic_pkg::*;
#(
    parameter int BUS_W   = 32,
    parameter int COORD_W = 2,
    localparam int FLIT_W = BUS_W + 2 * COORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_txd,
    input  logic              wr_dst,
    input  logic              err_clr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              tx_ack,
    output logic              tx_req,
    output logic [FLIT_W-1:0] tx_flit,
    output logic              busy,
    output logic              err
);
    typedef struct packed {
        tx_state_e          st;
        logic [BUS_W-1:0]   data;
        logic [COORD_W-1:0] dx;
        logic [COORD_W-1:0] dy;
        logic               err;
    } tx_regs_t;

    tx_regs_t q, d;

    assign busy    = (q.st != TX_IDLE);
    assign tx_req  = (q.st == TX_REQ_HIGH);
    assign tx_flit = {q.dy, q.dx, q.data};
    assign err     = q.err;

    always_comb begin
        d = q;
        case (q.st)
            TX_IDLE: begin
                if (wr_txd) d.data = wdata;
                if (wr_dst) begin
                    d.dx = wdata[COORD_W-1:0];
                    d.dy = wdata[2*COORD_W-1:COORD_W];
                    d.st = TX_REQ_HIGH;
                end
            end
            TX_REQ_HIGH: if (tx_ack)  d.st = TX_REQ_LOW;
            TX_REQ_LOW:  if (!tx_ack) d.st = TX_IDLE;
            default:     d.st = TX_IDLE;
        endcase
        if ((wr_txd || wr_dst) && busy) d.err = 1'b1;
        if (err_clr) d.err = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: TX_IDLE, data: '0, dx: '0, dy: '0, err: 1'b0};
        else        q <= d;
    end

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dst && !busy) |=> tx_req) else $error("R2 send did not start");
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_ack) |=> tx_req) else $error("R3 request dropped early");
    p_req_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_ack) |=> !tx_req) else $error("R3 request not released");
    p_flit_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(tx_flit))) else $error("R3 flit moved in flight");
    p_ignore_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_txd || wr_dst) && busy) |=> err) else $error("R4 error not flagged");
endmodule

// File: rtl/nic_rx_ctrl.sv
module nic_rx_ctrl
    import nic_pkg::*;
#(
    parameter int BUS_W   = 32,
    parameter int COORD_W = 2,
    localparam int FLIT_W = BUS_W + 2 * COORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_rx,
    input  logic               wr_ctl,
    input  logic               ctl_bit,
    input  logic               rx_req,
    input  logic [FLIT_W-1:0]  rx_flit,
    output logic               rx_ack,
    output logic               rx_valid,
    output logic [BUS_W-1:0]   rx_data,
    output logic [COORD_W-1:0] src_x,
    output logic [COORD_W-1:0] src_y,
    output logic               irq_en,
    output logic               irq
);
    typedef struct packed {
        rx_state_e          st;
        logic               valid;
        logic [BUS_W-1:0]   data;
        logic [COORD_W-1:0] sx;
        logic [COORD_W-1:0] sy;
        logic               ie;
    } rx_regs_t;

    rx_regs_t q, d;

    assign rx_ack   = (q.st == RX_ACKING);
    assign rx_valid = q.valid;
    assign rx_data  = q.data;
    assign src_x    = q.sx;
    assign src_y    = q.sy;
    assign irq_en   = q.ie;
    assign irq      = q.valid & q.ie;

    always_comb begin
        d = q;
        if (wr_ctl) d.ie = ctl_bit;
        if (rd_rx)  d.valid = 1'b0;
        case (q.st)
            RX_WAIT: begin
                // hold off acknowledge while a word is still unread
                if (rx_req && !q.valid) begin
                    d.st    = RX_ACKING;
                    d.valid = 1'b1;
                    d.data  = rx_flit[BUS_W-1:0];
                    d.sx    = rx_flit[BUS_W +: COORD_W];
                    d.sy    = rx_flit[BUS_W+COORD_W +: COORD_W];
                end
            end
            RX_ACKING: if (!rx_req) d.st = RX_WAIT;
            default:   d.st = RX_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: RX_WAIT, valid: 1'b0, data: '0, sx: '0, sy: '0, ie: 1'b0};
        else        q <= d;
    end

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack && !rx_req) |=> !rx_ack) else $error("R6 ack not released");
    p_holdoff_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ack) |=> !rx_ack) else $error("R7 ack while word held");
    p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rd_rx) |=> $stable(rx_data)) else $error("R7 held word overwritten");
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && rx_valid) |=> !rx_valid) else $error("R8 read did not clear");
endmodule

// File: rtl/nic_tile_port.sv
module nic_tile_port
    import nic_pkg::*;
#(
    parameter int BUS_W   = 32,
    parameter int ADDR_W  = 3,
    parameter int COORD_W = 2,
    parameter int MY_X    = 1,
    parameter int MY_Y    = 2,
    localparam int FLIT_W = BUS_W + 2 * COORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              tx_req,
    input  logic              tx_ack,
    output logic [FLIT_W-1:0] tx_flit,
    input  logic              rx_req,
    output logic              rx_ack,
    input  logic [FLIT_W-1:0] rx_flit
);
    // location fields are four bits wide in the status word: COORD_W <= 4
    localparam logic [COORD_W-1:0] OWN_X = COORD_W'(MY_X);
    localparam logic [COORD_W-1:0] OWN_Y = COORD_W'(MY_Y);

    logic wr_txd, wr_dst, wr_sts, wr_ctl, rd_rx;
    logic busy, err, rx_valid, irq_en;
    logic [BUS_W-1:0]   rx_data, status_word, ctrl_word;
    logic [COORD_W-1:0] src_x, src_y;

    always_comb begin
        status_word                        = '0;
        status_word[ST_BUSY]               = busy;
        status_word[ST_RXV]                = rx_valid;
        status_word[ST_ERR]                = err;
        status_word[ST_OWNX +: COORD_W]    = OWN_X;
        status_word[ST_OWNY +: COORD_W]    = OWN_Y;
        status_word[ST_SRCX +: COORD_W]    = src_x;
        status_word[ST_SRCY +: COORD_W]    = src_y;
        ctrl_word                          = '0;
        ctrl_word[0]                       = irq_en;
    end

    nic_bus_decode #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_dec (
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .status_word(status_word), .rx_word(rx_data), .ctrl_word(ctrl_word),
        .wr_txd(wr_txd), .wr_dst(wr_dst), .wr_sts(wr_sts), .wr_ctl(wr_ctl),
        .rd_rx(rd_rx), .bus_rdata(bus_rdata)
    );

    nic_tx_ctrl #(.BUS_W(BUS_W), .COORD_W(COORD_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .wr_txd(wr_txd), .wr_dst(wr_dst),
        .err_clr(wr_sts & bus_wdata[ST_ERR]), .wdata(bus_wdata),
        .tx_ack(tx_ack), .tx_req(tx_req), .tx_flit(tx_flit),
        .busy(busy), .err(err)
    );

    nic_rx_ctrl #(.BUS_W(BUS_W), .COORD_W(COORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rd_rx(rd_rx), .wr_ctl(wr_ctl),
        .ctl_bit(bus_wdata[0]), .rx_req(rx_req), .rx_flit(rx_flit),
        .rx_ack(rx_ack), .rx_valid(rx_valid), .rx_data(rx_data),
        .src_x(src_x), .src_y(src_y), .irq_en(irq_en), .irq(irq)
    );

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !bus_wdata[0]) |=> !irq) else $error("R9 irq with enable off");
    p_own_loc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sts |=> (status_word[ST_OWNX +: COORD_W] == OWN_X)) else $error("R10 location changed");
endmodule

// File: tb/sim_nic_tile_port.sv
`timescale 1ns/100ps
module sim_nic_tile_port;
    localparam int CW = 2;
    localparam int FW = 32 + 2 * CW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq, tx_req, rx_ack;
    logic tx_ack = 1'b0, rx_req = 1'b0;
    logic [FW-1:0] tx_flit;
    logic [FW-1:0] rx_flit = '0;

    int total = 0;
    int bad = 0;
    bit follow = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    nic_tile_port #(.BUS_W(32), .ADDR_W(3), .COORD_W(CW), .MY_X(1), .MY_Y(2)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .tx_req(tx_req), .tx_ack(tx_ack), .tx_flit(tx_flit),
        .rx_req(rx_req), .rx_ack(rx_ack), .rx_flit(rx_flit)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_ph;
    bit m_err, m_rxv, m_ack, m_ie;
    bit [31:0] m_data, m_rxd;
    bit [1:0] m_dx, m_dy, m_sx, m_sy;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_err = 0; m_rxv = 0; m_ack = 0; m_ie = 0;
            m_data = 0; m_rxd = 0; m_dx = 0; m_dy = 0; m_sx = 0; m_sy = 0;
        end else begin
            int n_ph;
            bit n_err, n_rxv, n_ack;
            bit w, r;
            n_ph = m_ph; n_err = m_err; n_rxv = m_rxv; n_ack = m_ack;
            w = bus_sel && bus_wr;
            r = bus_sel && !bus_wr;
            if (w && (bus_addr == 0 || bus_addr == 1) && m_ph != 0) n_err = 1;
            if (w && bus_addr == 3 && bus_wdata[2]) n_err = 0;
            if (m_ph == 0) begin
                if (w && bus_addr == 0) m_data = bus_wdata;
                if (w && bus_addr == 1) begin
                    m_dx = bus_wdata[1:0]; m_dy = bus_wdata[3:2]; n_ph = 1;
                end
            end else if (m_ph == 1) begin
                if (tx_ack) n_ph = 2;
            end else if (!tx_ack) n_ph = 0;
            if (w && bus_addr == 4) m_ie = bus_wdata[0];
            if (r && bus_addr == 2) n_rxv = 0;
            if (!m_ack) begin
                if (rx_req && !m_rxv) begin
                    n_ack = 1; n_rxv = 1;
                    m_rxd = rx_flit[31:0]; m_sx = rx_flit[33:32]; m_sy = rx_flit[35:34];
                end
            end else if (!rx_req) n_ack = 0;
            m_ph = n_ph; m_err = n_err; m_rxv = n_rxv; m_ack = n_ack;
        end
    end

    function automatic logic [31:0] model_rd();
        logic [31:0] v = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == 2) v = m_rxd;
            else if (bus_addr == 3)
                v = {8'h0, 2'b0, m_sy, 2'b0, m_sx, 2'b0, 2'd2, 2'b0, 2'd1,
                     5'b0, m_err, m_rxv, (m_ph != 0)};
            else if (bus_addr == 4) v = {31'b0, m_ie};
        end
        return v;
    endfunction

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            string rt;
            case (bus_addr)
                3'd2: rt = "R8";
                3'd3: rt = "R10";
                3'd4: rt = "R9";
                default: rt = "R11";
            endcase
            chk("R3 tx_req", {63'b0, tx_req}, {63'b0, (m_ph == 1)});
            chk("R2 tx_flit", {28'b0, tx_flit}, {28'b0, m_dy, m_dx, m_data});
            chk("R6 rx_ack", {63'b0, rx_ack}, {63'b0, m_ack});
            chk("R9 irq", {63'b0, irq}, {63'b0, m_rxv & m_ie});
            chk({rt, " rdata"}, {32'b0, bus_rdata}, {32'b0, model_rd()});
        end
    end

    // four-phase follower for the outgoing link
    always @(posedge clk) begin
        #1;
        if (follow) tx_ack = tx_req;
    end

    task automatic bus_write(input logic [2:0] a, input logic [31:0] dat);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = dat;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] dat);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        dat = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 0; bus_addr = 0;
    endtask

    task automatic send_rx(input logic [FW-1:0] f);
        @(posedge clk); #1;
        rx_req = 1; rx_flit = f;
        for (int i = 0; i < 60 && !rx_ack; i++) @(negedge clk);
        @(posedge clk); #1;
        rx_req = 0;
        for (int i = 0; i < 60 && rx_ack; i++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1 tx_req", {63'b0, tx_req}, 64'd0);
        chk("R1 rx_ack", {63'b0, rx_ack}, 64'd0);
        chk("R1 irq", {63'b0, irq}, 64'd0);
        bus_read(3, v); chk("R1 status", {32'b0, v}, 64'h2100);
        bus_read(2, v); chk("R1 rxdata", {32'b0, v}, 64'h0);
        bus_read(4, v); chk("R1 ctrl", {32'b0, v}, 64'h0);

        bus_read(5, v); chk("R11 read 5", {32'b0, v}, 64'h0);
        bus_write(6, 32'hFFFF_FFFF);
        bus_read(3, v); chk("R11 write 6", {32'b0, v}, 64'h2100);

        bus_write(0, 32'hA5A5_0001);
        bus_read(0, v); chk("R11 read 0", {32'b0, v}, 64'h0);
        bus_write(1, 32'h7);
        @(negedge clk);
        chk("R2 req up", {63'b0, tx_req}, 64'd1);
        chk("R2 flit", {28'b0, tx_flit}, 64'h7_A5A5_0001);
        bus_write(0, 32'h1234);
        bus_read(3, v); chk("R4 busy+err", {32'b0, v}, 64'h2105);
        chk("R4 flit kept", {28'b0, tx_flit}, 64'h7_A5A5_0001);

        follow = 1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R3 req done", {63'b0, tx_req}, 64'd0);
        bus_read(3, v); chk("R3 idle", {32'b0, v}, 64'h2104);
        bus_write(3, 32'hFFFF_FFFB);
        bus_read(3, v); chk("R10 own xy", {32'b0, v}, 64'h2104);
        bus_write(3, 32'h4);
        bus_read(3, v); chk("R5 err clear", {32'b0, v}, 64'h2100);

        // write in the cycle the outgoing handshake retires
        follow = 0;
        bus_write(0, 32'h55);
        bus_write(1, 32'h5);
        @(posedge clk); #1 tx_ack = 1;
        @(posedge clk); #1;
        tx_ack = 0; bus_sel = 1; bus_wr = 1; bus_addr = 1; bus_wdata = 32'h6;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        @(negedge clk);
        chk("R4 late write", {63'b0, tx_req}, 64'd0);
        chk("R4 late flit", {28'b0, tx_flit}, 64'h5_0000_0055);
        bus_read(3, v); chk("R4 late err", {32'b0, v}, 64'h2104);
        bus_write(3, 32'h4);

        send_rx({2'd2, 2'd1, 32'hDEAD_BEEF});
        bus_read(3, v); chk("R6 captured", {32'b0, v}, 64'h21_2102);
        chk("R9 irq off", {63'b0, irq}, 64'd0);
        bus_write(4, 32'h1);
        @(negedge clk);
        chk("R9 irq on", {63'b0, irq}, 64'd1);
        bus_read(4, v); chk("R9 ctrl", {32'b0, v}, 64'h1);

        fork
            send_rx({2'd3, 2'd0, 32'h0BAD_F00D});
            begin
                repeat (6) @(negedge clk);
                chk("R7 holdoff", {63'b0, rx_ack}, 64'd0);
                bus_read(2, v); chk("R7 R8 first word", {32'b0, v}, 64'hDEAD_BEEF);
            end
        join
        bus_read(3, v); chk("R8 second src", {32'b0, v}, 64'h30_2102);
        bus_read(2, v); chk("R8 second word", {32'b0, v}, 64'h0BAD_F00D);
        @(negedge clk);
        chk("R8 irq cleared", {63'b0, irq}, 64'd0);
        bus_write(4, 32'h0);
        bus_read(4, v); chk("R9 ctrl off", {32'b0, v}, 64'h0);

        repeat (3) @(posedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule